// File: doc/BRIEF.md
# Software write-protection command decoder

This block sits in front of a page-write nonvolatile memory and watches every byte-load cycle (address plus data) the host issues. It recognises the fixed multi-byte command sequences that unlock a page write, turn protection off, start a full-array erase, enter identification mode and leave it. It keeps one global protection flag, which is clear out of reset, and it decides whether the page load that follows may go ahead. A write that reaches a protected device without the unlock sequence starts a lockout interval. During that interval the decoder refuses further loads.

The byte-load stream is a valid/ready interface. A byte is taken on a rising clock edge where `ld_valid` and `ld_ready` are both high. `ld_ready` is low for the whole lockout interval. A byte offered while `ld_ready` is low is not taken and has no effect on any state. The sender may hold it or drop it. The page buffer outside the block reports the end of a page-load window with the plain pulse `page_end`. Reads in identification mode return fixed identification bytes on `id_data`. The command codes, command addresses, address mask, identification bytes and lockout length are all parameters.

Top module: `swp_cmd_decoder`

## Requirements
- R1: After reset the protection flag is clear, `write_permit` is 1, `id_mode` is 0, `lock_busy` is 0, `ld_ready` is 1 and `erase_start` is 0.
- R2: The three bytes 0xAA at address 0x5555, 0x55 at 0x2AAA and 0xA0 at 0x5555 arm the unlock. They set the protection flag if it was clear and open a page-load window, and `write_permit` reads 1 from the cycle after the third byte. Addresses are compared under the mask 0x7FFF.
- R3: A `page_end` pulse closes the window. The protection flag stays set, and `write_permit` reads 0 afterwards while protection is on.
- R4: While protection is on and no window is open, a byte that is not part of a command sequence raises `lock_busy` for exactly LOCK_CYCLES cycles, starting the cycle after it is taken.
- R5: With protection already on, the unlock sequence opens a window again. Every byte taken inside the window is page data: it neither starts a lockout nor is decoded as a command.
- R6: The six bytes AA, 55, 0x80, AA, 55, 0x20 (command addresses 0x5555/0x2AAA/0x5555/0x5555/0x2AAA/0x5555) clear the protection flag.
- R7: The six bytes AA, 55, 0x80, AA, 55, 0x10 at the same addresses produce a one-cycle `erase_start` pulse and leave the protection flag unchanged.
- R8: The bytes AA, 55, 0x90 set `id_mode`. In that mode `id_data` is 0xBF for `rd_addr` 0 and 0x08 for `rd_addr` 1. The bytes AA, 55, 0xF0 clear `id_mode`.
- R9: A byte that does not match the expected step of a sequence returns the decoder to idle, so later bytes of that sequence complete nothing.
- R10: A byte taken in the same cycle as `page_end` still belongs to the closing window. It causes no lockout, and `write_permit` is 0 afterwards.
- R11: `ld_ready` is 0 whenever `lock_busy` is 1. A byte offered then leaves the sequence decoder's state untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_valid | input | 1 | Byte-load offered |
| ld_ready | output | 1 | Byte-load can be taken (low during lockout) |
| ld_addr | input | ADDR_W | Byte-load address |
| ld_data | input | 8 | Byte-load data |
| page_end | input | 1 | Page-load window has ended (pulse) |
| rd_addr | input | ADDR_W | Read address for identification bytes |
| write_permit | output | 1 | Page load allowed |
| prot_on | output | 1 | Global protection flag |
| erase_start | output | 1 | One-cycle full-array erase request |
| id_mode | output | 1 | Identification mode active |
| id_data | output | 8 | Identification byte for rd_addr (0 outside the mode) |
| lock_busy | output | 1 | Lockout interval running |

## Verification
Two functions can land on the same edge. One is the end of a page-load window, signalled by `page_end`. The other is the acceptance of one more byte, which would be a lockout violation if the window were already shut. The bench drives both in one cycle on a protected device. The byte must count as window data, so `lock_busy` has to stay low while `write_permit` falls on the next cycle. A second overlap, a command byte offered while a lockout is running, is checked by sending the remaining bytes of the unlock sequence after the lockout ends and confirming that they open no window.

// File: rtl/swp_cmd_pkg.sv
package swp_cmd_pkg;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_G1,
    SQ_G2,
    SQ_X3,
    SQ_X4,
    SQ_X5
  } seq_state_t;

  typedef struct packed {
    logic unlock;
    logic id_enter;
    logic id_exit;
    logic dis;
    logic erase;
    logic plain;
  } cmd_ev_t;

endpackage

// File: rtl/swp_seq_fsm.sv
module swp_seq_fsm
  import swp_cmd_pkg::*;
#(
  parameter int          ADDR_W    = 17,
  parameter logic [ADDR_W-1:0] AMASK = 17'h07FFF,
  parameter logic [ADDR_W-1:0] ADDR_P = 17'h05555,
  parameter logic [ADDR_W-1:0] ADDR_Q = 17'h02AAA,
  parameter logic [7:0]  KEY_P     = 8'hAA,
  parameter logic [7:0]  KEY_Q     = 8'h55,
  parameter logic [7:0]  OP_WRITE  = 8'hA0,
  parameter logic [7:0]  OP_EXT    = 8'h80,
  parameter logic [7:0]  OP_ID     = 8'h90,
  parameter logic [7:0]  OP_EXIT   = 8'hF0,
  parameter logic [7:0]  OP_OFF    = 8'h20,
  parameter logic [7:0]  OP_ERASE  = 8'h10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        data,
  output cmd_ev_t           ev
);

  seq_state_t st, st_nxt;
  logic at_p, at_q;

  assign at_p = (addr & AMASK) == (ADDR_P & AMASK);
  assign at_q = (addr & AMASK) == (ADDR_Q & AMASK);

  always_comb begin
    st_nxt = st;
    ev     = '0;
    if (en) begin
      st_nxt = SQ_IDLE;
      unique case (st)
        SQ_IDLE: if (at_p && data == KEY_P) st_nxt = SQ_G1; else ev.plain = 1'b1;
        SQ_G1:   if (at_q && data == KEY_Q) st_nxt = SQ_G2; else ev.plain = 1'b1;
        SQ_G2: begin
          if (at_p && data == OP_WRITE)     ev.unlock   = 1'b1;
          else if (at_p && data == OP_ID)   ev.id_enter = 1'b1;
          else if (at_p && data == OP_EXIT) ev.id_exit  = 1'b1;
          else if (at_p && data == OP_EXT)  st_nxt      = SQ_X3;
          else                              ev.plain    = 1'b1;
        end
        SQ_X3:   if (at_p && data == KEY_P) st_nxt = SQ_X4; else ev.plain = 1'b1;
        SQ_X4:   if (at_q && data == KEY_Q) st_nxt = SQ_X5; else ev.plain = 1'b1;
        SQ_X5: begin
          if (at_p && data == OP_OFF)        ev.dis   = 1'b1;
          else if (at_p && data == OP_ERASE) ev.erase = 1'b1;
          else                               ev.plain = 1'b1;
        end
        default: ev.plain = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st <= SQ_IDLE;
    else        st <= st_nxt;
  end

  // R9: a completed or aborted step always lands back in idle
  assert_abort_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (en && ev.plain) |=> st == SQ_IDLE);

  // R11: without an accepted byte the sequence position does not move
  assert_hold_when_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(st));

endmodule

// File: rtl/swp_prot_ctrl.sv
module swp_prot_ctrl
  import swp_cmd_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  cmd_ev_t ev,
  input  logic    page_end,
  output logic    prot_on,
  output logic    window,
  output logic    id_mode,
  output logic    erase_start
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prot_on     <= 1'b0;
      window      <= 1'b0;
      id_mode     <= 1'b0;
      erase_start <= 1'b0;
    end else begin
      erase_start <= ev.erase;
      if (ev.unlock)   prot_on <= 1'b1;
      else if (ev.dis) prot_on <= 1'b0;
      if (ev.unlock)        window <= 1'b1;
      else if (page_end)    window <= 1'b0;
      if (ev.id_enter)      id_mode <= 1'b1;
      else if (ev.id_exit)  id_mode <= 1'b0;
    end
  end

  // R3: an open window implies protection is set
  assert_window_prot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    window |-> prot_on);

  // R3: ending a protected page never drops protection
  assert_prot_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (page_end && prot_on && !ev.dis) |=> prot_on);

  // R7: erase request lasts a single cycle
  assert_erase_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    erase_start |=> !erase_start);

endmodule

// File: rtl/swp_lock_timer.sv
module swp_lock_timer #(
  parameter int LOCK_CYCLES = 30000,
  localparam int CNT_W = $clog2(LOCK_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (start)      cnt <= CNT_W'(LOCK_CYCLES);
    else if (cnt != '0)  cnt <= cnt - CNT_W'(1);
  end

  assign busy = (cnt != '0);

  // R4: the interval counts down by one every cycle once started
  assert_lock_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !start) |=> (cnt == $past(cnt) - CNT_W'(1)));

endmodule

// File: rtl/swp_cmd_decoder.sv
module swp_cmd_decoder
  import swp_cmd_pkg::*;
#(
  parameter int          ADDR_W      = 17,
  parameter int          LOCK_CYCLES = 30000,
  parameter logic [ADDR_W-1:0] AMASK  = 17'h07FFF,
  parameter logic [ADDR_W-1:0] ADDR_P = 17'h05555,
  parameter logic [ADDR_W-1:0] ADDR_Q = 17'h02AAA,
  parameter logic [7:0]  KEY_P       = 8'hAA,
  parameter logic [7:0]  KEY_Q       = 8'h55,
  parameter logic [7:0]  OP_WRITE    = 8'hA0,
  parameter logic [7:0]  OP_EXT      = 8'h80,
  parameter logic [7:0]  OP_ID       = 8'h90,
  parameter logic [7:0]  OP_EXIT     = 8'hF0,
  parameter logic [7:0]  OP_OFF      = 8'h20,
  parameter logic [7:0]  OP_ERASE    = 8'h10,
  parameter logic [7:0]  MFR_BYTE    = 8'hBF,
  parameter logic [7:0]  DEV_BYTE    = 8'h08
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_valid,
  output logic              ld_ready,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [7:0]        ld_data,
  input  logic              page_end,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              write_permit,
  output logic              prot_on,
  output logic              erase_start,
  output logic              id_mode,
  output logic [7:0]        id_data,
  output logic              lock_busy
);

  logic    take, window, decode_en, violation;
  cmd_ev_t ev;

  assign ld_ready  = !lock_busy;
  assign take      = ld_valid && ld_ready;
  assign decode_en = take && !window;

  swp_seq_fsm #(
    .ADDR_W(ADDR_W), .AMASK(AMASK), .ADDR_P(ADDR_P), .ADDR_Q(ADDR_Q),
    .KEY_P(KEY_P), .KEY_Q(KEY_Q), .OP_WRITE(OP_WRITE), .OP_EXT(OP_EXT),
    .OP_ID(OP_ID), .OP_EXIT(OP_EXIT), .OP_OFF(OP_OFF), .OP_ERASE(OP_ERASE)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .en(decode_en),
    .addr(ld_addr), .data(ld_data), .ev(ev)
  );

  swp_prot_ctrl u_prot (
    .clk(clk), .rst_n(rst_n), .ev(ev), .page_end(page_end),
    .prot_on(prot_on), .window(window), .id_mode(id_mode),
    .erase_start(erase_start)
  );

  assign violation = ev.plain && prot_on;

  swp_lock_timer #(.LOCK_CYCLES(LOCK_CYCLES)) u_lock (
    .clk(clk), .rst_n(rst_n), .start(violation), .busy(lock_busy)
  );

  assign write_permit = !prot_on || window;

  always_comb begin
    id_data = 8'h00;
    if (id_mode) begin
      if (rd_addr == '0)                 id_data = MFR_BYTE;
      else if (rd_addr == ADDR_W'(1))    id_data = DEV_BYTE;
    end
  end

  // R4: a lockout only begins after a byte was taken on a protected device
  assert_lock_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_busy) |-> $past(ld_valid && prot_on && !window));

  // R5: bytes inside an open window never start a lockout
  assert_window_no_lock_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (take && window) |=> !$rose(lock_busy));

endmodule

// File: tb/swp_cmd_decoder_tb_top.sv
module swp_cmd_decoder_tb_top;

  localparam int AW = 17;
  localparam int LC = 20;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ld_valid = 1'b0;
  logic          ld_ready;
  logic [AW-1:0] ld_addr = '0;
  logic [7:0]    ld_data = '0;
  logic          page_end = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic          write_permit, prot_on, erase_start, id_mode, lock_busy;
  logic [7:0]    id_data;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  swp_cmd_decoder #(.ADDR_W(AW), .LOCK_CYCLES(LC)) dut_i (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_ready(ld_ready),
    .ld_addr(ld_addr), .ld_data(ld_data), .page_end(page_end),
    .rd_addr(rd_addr), .write_permit(write_permit), .prot_on(prot_on),
    .erase_start(erase_start), .id_mode(id_mode), .id_data(id_data),
    .lock_busy(lock_busy)
  );

  task automatic check(input logic ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic load(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk);
    ld_valid = 1'b1; ld_addr = a; ld_data = d;
    @(posedge clk); #1;
    ld_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulse_page_end();
    @(negedge clk);
    page_end = 1'b1;
    @(posedge clk); #1;
    page_end = 1'b0;
    @(negedge clk);
  endtask

  task automatic seq3(input logic [7:0] op);
    load(17'h05555, 8'hAA);
    load(17'h02AAA, 8'h55);
    load(17'h05555, op);
  endtask

  task automatic seq6(input logic [7:0] op);
    seq3(8'h80);
    load(17'h05555, 8'hAA);
    load(17'h02AAA, 8'h55);
    load(17'h05555, op);
  endtask

  task automatic wait_unlocked();
    while (lock_busy) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(prot_on == 1'b0,      "R1 prot_on",      prot_on, 0);
    check(write_permit == 1'b1, "R1 write_permit", write_permit, 1);
    check(id_mode == 1'b0,      "R1 id_mode",      id_mode, 0);
    check(lock_busy == 1'b0,    "R1 lock_busy",    lock_busy, 0);
    check(ld_ready == 1'b1,     "R1 ld_ready",     ld_ready, 1);
    check(erase_start == 1'b0,  "R1 erase_start",  erase_start, 0);
  endtask

  task automatic t_abort();
    load(17'h05555, 8'hAA);
    load(17'h02AAA, 8'h55);
    load(17'h05555, 8'h77);
    load(17'h05555, 8'hA0);
    load(17'h02AAA, 8'h55);
    load(17'h05555, 8'hA0);
    check(prot_on == 1'b0, "R9 aborted sequence left protection off", prot_on, 0);
  endtask

  task automatic t_first_unlock();
    seq3(8'hA0);
    check(prot_on == 1'b1,      "R2 protection set", prot_on, 1);
    check(write_permit == 1'b1, "R2 window open",    write_permit, 1);
    load(17'h00100, 8'h12);
    load(17'h00101, 8'h34);
    check(lock_busy == 1'b0,    "R2 page data no lockout", lock_busy, 0);
    pulse_page_end();
    check(write_permit == 1'b0, "R3 window closed",   write_permit, 0);
    check(prot_on == 1'b1,      "R3 protection kept", prot_on, 1);
  endtask

  task automatic t_lockout();
    int busy_n = 0;
    load(17'h00200, 8'h34);
    while (lock_busy) begin
      busy_n++;
      if (ld_ready) check(1'b0, "R11 ld_ready during lockout", ld_ready, 0);
      if (busy_n == 3) begin
        ld_valid = 1'b1; ld_addr = 17'h05555; ld_data = 8'hAA;
        @(posedge clk); #1;
        ld_valid = 1'b0;
      end
      @(negedge clk);
    end
    check(busy_n == LC, "R4 lockout length", busy_n, LC);
    load(17'h02AAA, 8'h55);
    load(17'h05555, 8'hA0);
    check(write_permit == 1'b0, "R11 byte during lockout ignored (no window)", write_permit, 0);
    check(lock_busy == 1'b1,    "R11 stray byte after lockout locks again", lock_busy, 1);
    wait_unlocked();
  endtask

  task automatic t_reunlock();
    seq3(8'hA0);
    check(write_permit == 1'b1, "R5 window reopened", write_permit, 1);
    load(17'h05555, 8'hAA);
    load(17'h02AAA, 8'h55);
    load(17'h05555, 8'h90);
    check(id_mode == 1'b0,   "R5 window bytes not decoded", id_mode, 0);
    check(lock_busy == 1'b0, "R5 window bytes no lockout",  lock_busy, 0);
  endtask

  task automatic t_same_cycle();
    @(negedge clk);
    ld_valid = 1'b1; ld_addr = 17'h00300; ld_data = 8'h5A; page_end = 1'b1;
    @(posedge clk); #1;
    ld_valid = 1'b0; page_end = 1'b0;
    @(negedge clk);
    check(lock_busy == 1'b0,    "R10 byte with page_end no lockout", lock_busy, 0);
    check(write_permit == 1'b0, "R10 window closed after overlap",   write_permit, 0);
  endtask

  task automatic t_id();
    seq3(8'h90);
    check(id_mode == 1'b1, "R8 id entry", id_mode, 1);
    rd_addr = 17'h00000; #1;
    check(id_data == 8'hBF, "R8 id byte at 0", id_data, 8'hBF);
    rd_addr = 17'h00001; #1;
    check(id_data == 8'h08, "R8 id byte at 1", id_data, 8'h08);
    seq3(8'hF0);
    check(id_mode == 1'b0, "R8 id exit", id_mode, 0);
    check(lock_busy == 1'b0, "R8 commands no lockout", lock_busy, 0);
  endtask

  task automatic t_erase();
    seq6(8'h10);
    check(erase_start == 1'b1, "R7 erase pulse high", erase_start, 1);
    @(negedge clk);
    check(erase_start == 1'b0, "R7 erase pulse one cycle", erase_start, 0);
    check(prot_on == 1'b1,     "R7 protection unchanged", prot_on, 1);
  endtask

  task automatic t_disable();
    seq6(8'h20);
    check(prot_on == 1'b0,      "R6 protection cleared", prot_on, 0);
    check(write_permit == 1'b1, "R6 writes permitted",   write_permit, 1);
    load(17'h00400, 8'h66);
    check(lock_busy == 1'b0,    "R6 plain byte no lockout", lock_busy, 0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_abort();
    t_first_unlock();
    t_lockout();
    t_reunlock();
    t_same_cycle();
    t_id();
    t_erase();
    t_disable();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

endmodule